// File: doc/BRIEF.md
# Double-Buffered Dual-Modulus Feedback Divider Controller

This block is the control path of a frequency synthesiser's feedback divider. A serial configuration word is clocked in while an enable line is high and is decoded when that line falls. Depending on two control bits at the tail of the word, it rewrites the standby copy of the divider settings, adjusts only the swallow count of the running settings, or is left to other logic. Two settings banks exist. A select input names the bank that drives the loop, so the standby bank can be prepared in advance and the synthesiser can change channel by flipping one pin.

The running settings drive a main (M) down-counter and a swallow (A) counter, both clocked by single-cycle strobes from an external dual-modulus prescaler. The modulus-control output stays high while the swallow count is nonzero. One feedback pulse goes to the phase detector per M strobes. New settings reach the counters only while the remaining main count is above three, or while the counter is idle. They are used at the next reload, so a count that is under way is never cut short or stretched. A swallow-only update is held back until the end of the current main cycle.

Top module: `fbdiv_ctrl`

## Requirements
- R1: After reset, mod_ctl, fb_pulse, a_err, pd_sense and pre_mode89 are all low.
- R2: With running main count M and swallow count A (0 <= A < M), fb_pulse rises once every M prescaler strobes, one cycle after the terminal strobe. mod_ctl is high during exactly the first A strobes of each cycle.
- R3: Bits enter most-significant first, one per ser_stb while ser_en is high. The last two bits shifted are the control code {C2,C1}. In a full word, A is bits [5:2], M is bits [15:6], the phase-detector sense is bit 16 and the 8/9 prescaler mode is bit 17. Codes 00 and 10 write the full word into the bank that buf_sel does not select. Such a write leaves the running division unchanged.
- R4: A word has no effect while ser_en is still high. It is decoded in the cycle in which ser_en is first seen low.
- R5: Control code 11 is ignored: no bank changes.
- R6: After buf_sel toggles, the selected bank is copied to the running settings only in a cycle where the remaining main count is greater than 3 or the counter is idle. Otherwise the copy waits for the next such cycle.
- R7: New running settings never change the cycle in progress. They take effect at the next reload, and the main count moves only on prescaler strobes.
- R8: Control code 01 is a 6-bit word with A in bits [5:2]. The new A is applied at the end of the current main cycle. M, sense and mode are left as they were.
- R9: If the relevant prescaler mode is 8/9 (the word's own bit 17 for a full word, the running mode for an A-only word) and A bit 3 is 1, then a_err pulses for one cycle after decode and the stored A has bit 3 cleared.
- R10: pd_sense and pre_mode89 follow the running settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial load enable; falling edge decodes the word |
| ser_stb | input | 1 | Shift strobe, one cycle per bit |
| ser_dat | input | 1 | Serial data bit |
| buf_sel | input | 1 | Selects the bank that drives the loop |
| pre_pulse | input | 1 | One-cycle strobe per prescaler output pulse |
| mod_ctl | output | 1 | Modulus control to the prescaler |
| fb_pulse | output | 1 | Feedback pulse to the phase detector |
| pd_sense | output | 1 | Running phase-detector sense |
| pre_mode89 | output | 1 | Running prescaler mode (1 = 8/9) |
| a_err | output | 1 | One-cycle flag: A bit 3 set while in 8/9 mode |

## Verification
The bench sweeps every main count from 4 to 12 against every legal swallow count. It measures the strobe spacing between feedback pulses and the number of modulus-control strobes, which catches off-by-one reloads and miscounted swallow phases. Channel switches are made both deep inside a cycle and with only three strobes left. The first case must take effect in the next cycle; the second must leave one extra old cycle, which separates a correct safe window from a missing or shifted one. Swallow-only words, reference-code words, writes while enable is held high and 8/9 words with bit 3 set are each followed by cycle measurements. These show whether the change landed, landed too early, or was wrongly dropped.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int A_W       = 4;
  localparam int M_W       = 10;
  localparam int WORD_W    = 24;
  localparam int CTL_W     = 2;
  localparam int A_LSB     = CTL_W;
  localparam int M_LSB     = A_LSB + A_W;
  localparam int SENSE_BIT = M_LSB + M_W;
  localparam int MODE_BIT  = SENSE_BIT + 1;
  localparam int SAFE_MIN  = 3;

  typedef struct packed {
    logic           mode89;
    logic           sense;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
  } div_cfg_t;

  typedef enum logic [CTL_W-1:0] {
    CTL_BANK_A = 2'b00,
    CTL_AONLY  = 2'b01,
    CTL_BANK_B = 2'b10,
    CTL_REFW   = 2'b11
  } ctl_code_t;
endpackage

// File: rtl/fbdiv_shift.sv
module fbdiv_shift
  import fbdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ser_en,
  input  logic     ser_stb,
  input  logic     ser_dat,
  output logic     wr_full,
  output logic     wr_aonly,
  output div_cfg_t cfg_in
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              en_q;
  logic              fall;
  ctl_code_t         code;

  always_comb begin
    sr_d = sr_q;
    if (ser_en && ser_stb) sr_d = {sr_q[WORD_W-2:0], ser_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      en_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      en_q <= ser_en;
    end
  end

  always_comb begin
    fall          = en_q & ~ser_en;
    code          = ctl_code_t'(sr_q[CTL_W-1:0]);
    wr_full       = fall && (code == CTL_BANK_A || code == CTL_BANK_B);
    wr_aonly      = fall && (code == CTL_AONLY);
    cfg_in.a      = sr_q[A_LSB +: A_W];
    cfg_in.m      = sr_q[M_LSB +: M_W];
    cfg_in.sense  = sr_q[SENSE_BIT];
    cfg_in.mode89 = sr_q[MODE_BIT];
  end
endmodule

// File: rtl/fbdiv_bank.sv
module fbdiv_bank
  import fbdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           wr_full,
  input  logic           wr_aonly,
  input  div_cfg_t       cfg_in,
  input  logic [M_W-1:0] m_rem,
  input  logic           reload,
  output div_cfg_t       act,
  output logic [A_W-1:0] reload_a,
  output logic           a_err
);
  div_cfg_t       full_fix, sel_cfg, act_d;
  logic [A_W-1:0] aonly_fix, anew_q, anew_d;
  logic           full_bad, aonly_bad, apend_q, apend_d;
  logic           sel_q, pend_q, pend_d, safe, xfer, err_d;

  always_comb begin
    full_bad  = cfg_in.mode89 && cfg_in.a[A_W-1];
    aonly_bad = act.mode89 && cfg_in.a[A_W-1];
    full_fix  = cfg_in;
    if (full_bad) full_fix.a[A_W-1] = 1'b0;
    aonly_fix = cfg_in.a;
    if (aonly_bad) aonly_fix[A_W-1] = 1'b0;
  end

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      div_cfg_t q, d;
      always_comb begin
        d = q;
        if (wr_full && (sel != 1'(b))) d = full_fix;
        if (wr_aonly && (sel == 1'(b))) d.a = aonly_fix;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

  always_comb begin
    sel_cfg  = sel ? g_bank[1].q : g_bank[0].q;
    safe     = (m_rem > M_W'(SAFE_MIN)) || (m_rem == '0);
    xfer     = pend_q && safe;
    pend_d   = (sel != sel_q) || (pend_q && !xfer);
    act_d    = act;
    if (xfer) act_d = sel_cfg;
    apend_d  = apend_q;
    anew_d   = anew_q;
    if (reload && apend_q) begin
      act_d.a = anew_q;
      apend_d = 1'b0;
    end
    if (wr_aonly) begin
      apend_d = 1'b1;
      anew_d  = aonly_fix;
    end
    reload_a = apend_q ? anew_q : act.a;
    err_d    = (wr_full && full_bad) || (wr_aonly && aonly_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b1;
      apend_q <= 1'b0;
      anew_q  <= '0;
      a_err   <= 1'b0;
    end else begin
      act     <= act_d;
      sel_q   <= sel;
      pend_q  <= pend_d;
      apend_q <= apend_d;
      anew_q  <= anew_d;
      a_err   <= err_d;
    end
  end
endmodule

// File: rtl/fbdiv_count.sv
module fbdiv_count
  import fbdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_pulse,
  input  logic [M_W-1:0] ld_m,
  input  logic [A_W-1:0] ld_a,
  output logic [M_W-1:0] m_rem,
  output logic           reload,
  output logic           mod_ctl,
  output logic           fb_pulse
);
  logic [M_W-1:0] m_d;
  logic [A_W-1:0] a_q, a_d;
  logic           fb_d;

  always_comb begin
    m_d    = m_rem;
    a_d    = a_q;
    fb_d   = 1'b0;
    reload = 1'b0;
    if (pre_pulse) begin
      if (m_rem <= M_W'(1)) begin
        fb_d = (m_rem == M_W'(1));
        if (ld_m != '0) begin
          m_d    = ld_m;
          a_d    = ld_a;
          reload = 1'b1;
        end else begin
          m_d = '0;
          a_d = '0;
        end
      end else begin
        m_d = m_rem - M_W'(1);
        if (a_q != '0) a_d = a_q - A_W'(1);
      end
    end
    mod_ctl = (a_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem    <= '0;
      a_q      <= '0;
      fb_pulse <= 1'b0;
    end else begin
      m_rem    <= m_d;
      a_q      <= a_d;
      fb_pulse <= fb_d;
    end
  end
endmodule

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ser_stb,
  input  logic ser_dat,
  input  logic buf_sel,
  input  logic pre_pulse,
  output logic mod_ctl,
  output logic fb_pulse,
  output logic pd_sense,
  output logic pre_mode89,
  output logic a_err
);
  logic [1:0]     rst_pipe;
  logic           rst_s_n;
  logic           wr_full, wr_aonly, reload;
  div_cfg_t       cfg_in, act;
  logic [M_W-1:0] m_rem;
  logic [A_W-1:0] reload_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  fbdiv_shift u_shift (
    .clk(clk), .rst_n(rst_s_n), .ser_en(ser_en), .ser_stb(ser_stb),
    .ser_dat(ser_dat), .wr_full(wr_full), .wr_aonly(wr_aonly), .cfg_in(cfg_in)
  );

  fbdiv_bank u_bank (
    .clk(clk), .rst_n(rst_s_n), .sel(buf_sel), .wr_full(wr_full),
    .wr_aonly(wr_aonly), .cfg_in(cfg_in), .m_rem(m_rem), .reload(reload),
    .act(act), .reload_a(reload_a), .a_err(a_err)
  );

  fbdiv_count u_count (
    .clk(clk), .rst_n(rst_s_n), .pre_pulse(pre_pulse), .ld_m(act.m),
    .ld_a(reload_a), .m_rem(m_rem), .reload(reload), .mod_ctl(mod_ctl),
    .fb_pulse(fb_pulse)
  );

  assign pd_sense   = act.sense;
  assign pre_mode89 = act.mode89;
endmodule

// File: rtl/fbdiv_ctrl_chk.sv
module fbdiv_ctrl_chk
  import fbdiv_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           ser_en,
  input logic           pre_pulse,
  input logic           fb_pulse,
  input logic           mod_ctl,
  input logic           a_err,
  input logic [M_W-1:0] m_rem,
  input logic [M_W-1:0] act_m
);
  assert_fb_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(pre_pulse));

  assert_mc_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rem == '0) |-> !mod_ctl);

  assert_xfer_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_m) |-> ($past(m_rem) > M_W'(SAFE_MIN) || $past(m_rem) == '0));

  assert_count_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_pulse |=> $stable(m_rem));

  assert_err_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_err |-> (!$past(ser_en) && $past(ser_en, 2)));
endmodule

bind fbdiv_ctrl fbdiv_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .ser_en(ser_en), .pre_pulse(pre_pulse),
  .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .a_err(a_err), .m_rem(m_rem),
  .act_m(act.m)
);

// File: tb/fbdiv_ctrl_bench.sv
module fbdiv_ctrl_bench;
  logic clk, rst_n, ser_en, ser_stb, ser_dat, buf_sel, pre_pulse;
  logic mod_ctl, fb_pulse, pd_sense, pre_mode89, a_err;
  int   n_chk, n_bad;
  logic sel;
  logic last_err;

  fbdiv_ctrl u_fbdiv_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_stb(ser_stb),
    .ser_dat(ser_dat), .buf_sel(buf_sel), .pre_pulse(pre_pulse),
    .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .pd_sense(pd_sense),
    .pre_mode89(pre_mode89), .a_err(a_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mkw(input int m, input int a, input bit sense,
                                      input bit mode, input bit [1:0] ctl);
    logic [23:0] w;
    w        = '0;
    w[1:0]   = ctl;
    w[5:2]   = 4'(a);
    w[15:6]  = 10'(m);
    w[16]    = sense;
    w[17]    = mode;
    return w;
  endfunction

  task automatic shift_only(input logic [23:0] w, input int nb);
    ser_en = 1'b1;
    @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_dat = w[i];
      ser_stb = 1'b1;
      @(negedge clk);
      ser_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic end_word();
    ser_en = 1'b0;
    @(negedge clk);
    last_err = a_err;
    @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int nb);
    shift_only(w, nb);
    end_word();
  endtask

  task automatic pulse(output logic mc, output logic fb);
    mc = mod_ctl;
    pre_pulse = 1'b1;
    @(negedge clk);
    pre_pulse = 1'b0;
    fb = fb_pulse;
    @(negedge clk);
  endtask

  task automatic sync_fb();
    logic mc, fb;
    fb = 1'b0;
    for (int k = 0; k < 3000 && !fb; k++) pulse(mc, fb);
  endtask

  task automatic measure_from(input int n0, input int h0, output int n, output int h);
    logic mc, fb;
    n  = n0;
    h  = h0;
    fb = 1'b0;
    for (int k = 0; k < 3000 && !fb; k++) begin
      pulse(mc, fb);
      n++;
      if (mc) h++;
    end
  endtask

  task automatic run_pulses(input int cnt, output int h);
    logic mc, fb;
    h = 0;
    for (int k = 0; k < cnt; k++) begin
      pulse(mc, fb);
      if (mc) h++;
    end
  endtask

  task automatic program_switch(input int m, input int a, input bit sense, input bit mode);
    send(mkw(m, a, sense, mode, sel ? 2'b00 : 2'b10), 24);
    sel     = ~sel;
    buf_sel = sel;
    @(negedge clk);
    sync_fb();
    sync_fb();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R2: watchdog expired, actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, h, h2;
    n_chk = 0; n_bad = 0; sel = 1'b0; last_err = 1'b0;
    rst_n = 1'b0; ser_en = 1'b0; ser_stb = 1'b0; ser_dat = 1'b0;
    buf_sel = 1'b0; pre_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mod_ctl", int'(mod_ctl), 0);
    chk("R1 fb_pulse", int'(fb_pulse), 0);
    chk("R1 a_err", int'(a_err), 0);
    chk("R1 pd_sense", int'(pd_sense), 0);
    chk("R1 pre_mode89", int'(pre_mode89), 0);

    // R2/R3 sweep of main and swallow counts
    for (int m = 4; m <= 12; m++) begin
      for (int a = 0; a < m && a < 16; a++) begin
        program_switch(m, a, 1'b0, 1'b0);
        measure_from(0, 0, n, h);
        chk("R2 cycle length", n, m);
        chk("R2 swallow strobes", h, a);
      end
    end

    // R3 inactive write does not disturb the loop
    program_switch(10, 3, 1'b0, 1'b0);
    send(mkw(5, 1, 1'b0, 1'b0, sel ? 2'b00 : 2'b10), 24);
    sync_fb();
    measure_from(0, 0, n, h);
    chk("R3 inactive write M", n, 10);
    chk("R3 inactive write A", h, 3);

    // R5 reference code ignored: switching must bring out 5/1
    send(mkw(7, 6, 1'b1, 1'b0, 2'b11), 24);
    sel = ~sel; buf_sel = sel;
    @(negedge clk);
    sync_fb(); sync_fb();
    measure_from(0, 0, n, h);
    chk("R5 ref word M", n, 5);
    chk("R5 ref word A", h, 1);
    chk("R5 ref word sense", int'(pd_sense), 0);

    // R8/R7 A-only mid-cycle: current cycle keeps A=3, next uses 7
    program_switch(10, 3, 1'b0, 1'b0);
    run_pulses(2, h2);
    send(mkw(0, 7, 1'b0, 1'b0, 2'b01), 6);
    chk("R9 no err aonly", int'(last_err), 0);
    measure_from(2, h2, n, h);
    chk("R7 cycle in progress M", n, 10);
    chk("R8 current A kept", h, 3);
    measure_from(0, 0, n, h);
    chk("R8 aonly M kept", n, 10);
    chk("R8 aonly new A", h, 7);

    // R4 held enable: no effect until ser_en falls
    shift_only(mkw(0, 2, 1'b0, 1'b0, 2'b01), 6);
    sync_fb(); sync_fb();
    measure_from(0, 0, n, h);
    chk("R4 held enable A", h, 7);
    end_word();
    sync_fb();
    measure_from(0, 0, n, h);
    chk("R4 after fall A", h, 2);
    send(mkw(0, 7, 1'b0, 1'b0, 2'b01), 6);
    sync_fb();

    // R6 toggle with 3 strobes left: one more old cycle
    send(mkw(6, 2, 1'b0, 1'b0, sel ? 2'b00 : 2'b10), 24);
    sync_fb();
    run_pulses(7, h2);
    sel = ~sel; buf_sel = sel;
    @(negedge clk);
    sync_fb();
    measure_from(0, 0, n, h);
    chk("R6 late toggle old M", n, 10);
    chk("R6 late toggle old A", h, 7);
    measure_from(0, 0, n, h);
    chk("R6 late toggle new M", n, 6);
    chk("R6 late toggle new A", h, 2);

    // R6/R7 toggle inside window: current cycle intact, next new
    send(mkw(8, 5, 1'b0, 1'b0, sel ? 2'b00 : 2'b10), 24);
    sync_fb();
    run_pulses(2, h2);
    sel = ~sel; buf_sel = sel;
    @(negedge clk);
    measure_from(2, h2, n, h);
    chk("R7 switched cycle M", n, 6);
    chk("R7 switched cycle A", h, 2);
    measure_from(0, 0, n, h);
    chk("R6 early toggle new M", n, 8);
    chk("R6 early toggle new A", h, 5);

    // R9/R10 8/9 mode with A bit 3 set
    send(mkw(9, 9, 1'b1, 1'b1, sel ? 2'b00 : 2'b10), 24);
    chk("R9 full word err", int'(last_err), 1);
    chk("R9 err is one cycle", int'(a_err), 0);
    sel = ~sel; buf_sel = sel;
    @(negedge clk);
    sync_fb(); sync_fb();
    measure_from(0, 0, n, h);
    chk("R9 forced A M", n, 9);
    chk("R9 forced A", h, 1);
    chk("R10 pd_sense", int'(pd_sense), 1);
    chk("R10 pre_mode89", int'(pre_mode89), 1);
    send(mkw(0, 12, 1'b0, 1'b0, 2'b01), 6);
    chk("R9 aonly err", int'(last_err), 1);
    sync_fb();
    measure_from(0, 0, n, h);
    chk("R9 aonly forced A", h, 4);
    chk("R8 aonly keeps sense", int'(pd_sense), 1);
    send(mkw(0, 5, 1'b0, 1'b0, 2'b01), 6);
    chk("R9 legal aonly no err", int'(last_err), 0);
    sync_fb();
    measure_from(0, 0, n, h);
    chk("R9 legal aonly A", h, 5);
    chk("R8 aonly keeps mode", int'(pre_mode89), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule